// File: doc/BRIEF.md
# Sponge Rate Block Assembler

This block feeds the multi-block absorb port of a Keccak permutation core. It builds the absorbed message one byte per clock into a full rate block and hands the block over. The message starts with a fixed-length prefix, taken from a register captured at start. The rest of the message is streamed from a byte-wide memory with one cycle of read latency. After the last message byte the block inserts the domain suffix for SHA3-256 or SHAKE256, then zero bytes, and sets the top bit of the last byte of the final block.

A run starts with a one-cycle `start` pulse while the block is idle. The block samples the mode, the total message length (prefix included) and the prefix at that pulse. Each finished block is presented on `blk_data` with `blk_valid` held high. The core takes the block by dropping `absorb_ready`. Later it raises `absorb_ready` again to show that the permutation is finished. The assembler then fills the next block, or goes idle after the final one. `absorb_ready` must be high when `start` is given.

The memory address is a combinational function of the byte index being fetched. The registered read therefore returns the byte on the next clock, and each byte reaches the block register two edges after its index is formed.

Top module: `sponge_block_asm`

## Requirements
- R1: While reset is asserted and right after it is released, `blk_valid` and `blk_last` are 0 and `blk_data` is all zeros.
- R2: Message byte index g (counted from 0 across the whole padded stream) with g < 32 takes byte g of `prefix`, i.e. `prefix[8g+7:8g]`. Byte p of a block appears on `blk_data[8p+7:8p]`.
- R3: For 32 <= g < `msg_len`, byte g is the memory byte at address g-32. `mem_addr` is driven combinationally from the index, the memory returns that address's byte on the following clock, and consecutive fetch cycles within a block step `mem_addr` by one.
- R4: Byte g = `msg_len` is the suffix: 0x06 when `mode` is 0 (SHA3-256) and 0x1F when `mode` is 1 (SHAKE256).
- R5: Every byte after the suffix and before the final byte of the final block is 0x00.
- R6: The final byte of the final block has 0x80 OR-ed in. When it is also the suffix byte, it reads 0x86 (mode 0) or 0x9F (mode 1).
- R7: A message of L bytes yields floor(L/136)+1 blocks of 136 bytes. So 800, 1120 and 1600 bytes give 6, 9 and 12 blocks, and a length that is an exact multiple of 136 gets one extra, fully padded block. `blk_last` is 1 only with the final block, and only while `blk_valid` is 1.
- R8: Once raised, `blk_valid` stays high with `blk_data` and `blk_last` unchanged for as long as `absorb_ready` stays high.
- R9: On the clock after `absorb_ready` is seen low with `blk_valid` high, `blk_valid` falls. It stays low until `absorb_ready` has returned high and the next block is complete. After the final block, no further block appears without a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin absorbing a message (idle only) |
| mode | input | 1 | Padding domain: 0 SHA3-256, 1 SHAKE256 |
| msg_len | input | LEN_W | Total message length in bytes, prefix included (>= PREFIX_BYTES) |
| prefix | input | 8*PREFIX_BYTES | Prefix bytes, byte 0 in the low bits |
| mem_addr | output | ADDR_W | Read address of the message memory |
| mem_rdata | input | 8 | Read data, one clock after the address |
| absorb_ready | input | 1 | Core ready; drops on accept, rises when the permutation is done |
| blk_data | output | 8*RATE_BYTES | Assembled rate block |
| blk_valid | output | 1 | Block presented to the core |
| blk_last | output | 1 | Presented block is the final one |

## Verification
The bench builds the block with its default parameters: a 136-byte rate, a 32-byte prefix, 12-bit lengths and a 12-bit memory address. These values allow messages up to 1600 bytes, which span 12 blocks. The lengths used place the suffix at every kind of position: in the middle of a block, on the final byte of a block (giving the combined 0x86 and 0x9F bytes), and just past a block boundary, which forces an all-padding block. A zero-length memory stream (a 32-byte message) is also run. Each block is compared against a software model of the padding rule. The acceptance delay and the permutation delay are varied so that both the holding of a block and the quiet window after acceptance are exercised.

// File: rtl/sba_pkg.sv
package sba_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_FILL,
      S_FLUSH,
      S_SEND,
      S_PERM
   } sba_state_e;

   typedef enum logic [1:0] {
      SRC_PFX,
      SRC_MEM,
      SRC_SFX,
      SRC_ZERO
   } sba_src_e;

   localparam logic [7:0] SFX_SHA3  = 8'h06;
   localparam logic [7:0] SFX_SHAKE = 8'h1F;
   localparam logic [7:0] PAD_END   = 8'h80;
endpackage

// File: rtl/sba_ctl.sv
module sba_ctl
   import sba_pkg::*;
#(
   parameter int RATE_BYTES = 136,
   parameter int G_W        = 13,
   parameter int POS_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             absorb_ready,
   input  logic [G_W-1:0]   len_q,
   output sba_state_e       state,
   output logic [G_W-1:0]   g_idx,
   output logic [POS_W-1:0] pos,
   output logic             issue,
   output logic             last_blk
);
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(RATE_BYTES - 1);
   localparam logic [G_W-1:0]   RATE_G   = G_W'(RATE_BYTES);

   sba_state_e       st_q;
   logic [G_W-1:0]   base_q;
   logic [POS_W-1:0] pos_q;

   assign state    = st_q;
   assign pos      = pos_q;
   assign g_idx    = base_q + G_W'(pos_q);
   assign issue    = (st_q == S_FILL);
   assign last_blk = (base_q + RATE_G) > len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         base_q <= '0;
         pos_q  <= '0;
      end else begin
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  base_q <= '0;
                  pos_q  <= '0;
                  st_q   <= S_FILL;
               end
            end
            S_FILL: begin
               if (pos_q == POS_LAST) begin
                  pos_q <= '0;
                  st_q  <= S_FLUSH;
               end else begin
                  pos_q <= pos_q + 1'b1;
               end
            end
            S_FLUSH: st_q <= S_SEND;
            S_SEND: begin
               if (!absorb_ready) st_q <= S_PERM;
            end
            S_PERM: begin
               if (absorb_ready) begin
                  if (last_blk) begin
                     st_q <= S_IDLE;
                  end else begin
                     base_q <= base_q + RATE_G;
                     st_q   <= S_FILL;
                  end
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sba_lane_sel.sv
module sba_lane_sel
   import sba_pkg::*;
#(
   parameter int PREFIX_BYTES = 32,
   parameter int RATE_BYTES   = 136,
   parameter int G_W          = 13,
   parameter int POS_W        = 8
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        issue,
   input  logic [G_W-1:0]                              g_idx,
   input  logic [POS_W-1:0]                            pos,
   input  logic [G_W-1:0]                              len_q,
   input  logic                                        mode_q,
   input  logic                                        last_blk,
   input  logic [((PREFIX_BYTES > 0) ? PREFIX_BYTES : 1)*8-1:0] prefix_q,
   input  logic [7:0]                                  mem_rdata,
   output logic                                        wr_en,
   output logic [POS_W-1:0]                            wr_pos,
   output logic [7:0]                                  wr_byte
);
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(RATE_BYTES - 1);
   localparam int PIDX_W = (PREFIX_BYTES > 1) ? $clog2(PREFIX_BYTES) : 1;

   logic       is_pfx;
   logic [7:0] pfx_byte;
   sba_src_e   src_d;

   // prefix path exists only when the message carries a register prefix
   generate
      if (PREFIX_BYTES > 0) begin : g_pfx
         logic [PIDX_W-1:0] pidx;
         assign pidx     = g_idx[PIDX_W-1:0];
         assign is_pfx   = g_idx < G_W'(PREFIX_BYTES);
         assign pfx_byte = prefix_q[8*pidx +: 8];
      end else begin : g_no_pfx
         logic unused_pfx;
         assign unused_pfx = ^prefix_q;
         assign is_pfx     = 1'b0;
         assign pfx_byte   = 8'h00;
      end
   endgenerate

   always_comb begin
      if (is_pfx)              src_d = SRC_PFX;
      else if (g_idx < len_q)  src_d = SRC_MEM;
      else if (g_idx == len_q) src_d = SRC_SFX;
      else                     src_d = SRC_ZERO;
   end

   // stage aligned with the registered memory read
   logic             v_q;
   logic [POS_W-1:0] pos_q;
   sba_src_e         src_q;
   logic [7:0]       pfx_q;
   logic             end_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         pos_q <= '0;
         src_q <= SRC_ZERO;
         pfx_q <= '0;
         end_q <= 1'b0;
      end else begin
         v_q   <= issue;
         pos_q <= pos;
         src_q <= src_d;
         pfx_q <= pfx_byte;
         end_q <= last_blk && (pos == POS_LAST);
      end
   end

   logic [7:0] base_byte;
   always_comb begin
      case (src_q)
         SRC_PFX: base_byte = pfx_q;
         SRC_MEM: base_byte = mem_rdata;
         SRC_SFX: base_byte = mode_q ? SFX_SHAKE : SFX_SHA3;
         default: base_byte = 8'h00;
      endcase
   end

   assign wr_en   = v_q;
   assign wr_pos  = pos_q;
   assign wr_byte = base_byte | (end_q ? PAD_END : 8'h00);
endmodule

// File: rtl/sba_block_reg.sv
module sba_block_reg #(
   parameter int RATE_BYTES = 136,
   parameter int POS_W      = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [POS_W-1:0]        wr_pos,
   input  logic [7:0]              wr_byte,
   output logic [RATE_BYTES*8-1:0] blk
);
   generate
      for (genvar i = 0; i < RATE_BYTES; i++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n)
               blk[8*i +: 8] <= 8'h00;
            else if (wr_en && (wr_pos == POS_W'(i)))
               blk[8*i +: 8] <= wr_byte;
         end
      end
   endgenerate
endmodule

// File: rtl/sponge_block_asm.sv
module sponge_block_asm
   import sba_pkg::*;
#(
   parameter int RATE_BYTES   = 136,
   parameter int PREFIX_BYTES = 32,
   parameter int LEN_W        = 12,
   parameter int ADDR_W       = 12,
   localparam int PFX_BITS    = ((PREFIX_BYTES > 0) ? PREFIX_BYTES : 1) * 8,
   localparam int BLK_BITS    = RATE_BYTES * 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                mode,
   input  logic [LEN_W-1:0]    msg_len,
   input  logic [PFX_BITS-1:0] prefix,
   output logic [ADDR_W-1:0]   mem_addr,
   input  logic [7:0]          mem_rdata,
   input  logic                absorb_ready,
   output logic [BLK_BITS-1:0] blk_data,
   output logic                blk_valid,
   output logic                blk_last
);
   localparam int G_W   = LEN_W + 1;
   localparam int POS_W = $clog2(RATE_BYTES);

   generate
      if (RATE_BYTES < 2) begin : g_bad_rate
         $error("rate must hold at least two bytes");
      end
      if (RATE_BYTES > (1 << LEN_W)) begin : g_bad_len
         $error("length field too narrow for one rate block");
      end
      if (PREFIX_BYTES < 0) begin : g_bad_pfx
         $error("prefix length cannot be negative");
      end
   endgenerate

   sba_state_e       state;
   logic [G_W-1:0]   g_idx;
   logic [POS_W-1:0] pos;
   logic             issue;
   logic             last_blk;

   logic [G_W-1:0]      len_q;
   logic                mode_q;
   logic [PFX_BITS-1:0] prefix_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q    <= '0;
         mode_q   <= 1'b0;
         prefix_q <= '0;
      end else if (start && state == S_IDLE) begin
         len_q    <= G_W'(msg_len);
         mode_q   <= mode;
         prefix_q <= prefix;
      end
   end

   sba_ctl #(
      .RATE_BYTES(RATE_BYTES),
      .G_W       (G_W),
      .POS_W     (POS_W)
   ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .absorb_ready(absorb_ready),
      .len_q       (len_q),
      .state       (state),
      .g_idx       (g_idx),
      .pos         (pos),
      .issue       (issue),
      .last_blk    (last_blk)
   );

   // combinational address: the memory registers it, data lands next cycle
   logic [G_W-1:0] mem_off;
   assign mem_off  = g_idx - G_W'(PREFIX_BYTES);
   assign mem_addr = ADDR_W'(mem_off);

   logic             wr_en;
   logic [POS_W-1:0] wr_pos;
   logic [7:0]       wr_byte;

   sba_lane_sel #(
      .PREFIX_BYTES(PREFIX_BYTES),
      .RATE_BYTES  (RATE_BYTES),
      .G_W         (G_W),
      .POS_W       (POS_W)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (issue),
      .g_idx    (g_idx),
      .pos      (pos),
      .len_q    (len_q),
      .mode_q   (mode_q),
      .last_blk (last_blk),
      .prefix_q (prefix_q),
      .mem_rdata(mem_rdata),
      .wr_en    (wr_en),
      .wr_pos   (wr_pos),
      .wr_byte  (wr_byte)
   );

   sba_block_reg #(
      .RATE_BYTES(RATE_BYTES),
      .POS_W     (POS_W)
   ) u_blk (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_pos (wr_pos),
      .wr_byte(wr_byte),
      .blk    (blk_data)
   );

   assign blk_valid = (state == S_SEND);
   assign blk_last  = (state == S_SEND) && last_blk;
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
   parameter int RATE_BYTES = 136,
   parameter int ADDR_W     = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    blk_valid,
   input logic                    blk_last,
   input logic [RATE_BYTES*8-1:0] blk_data,
   input logic                    absorb_ready,
   input logic [ADDR_W-1:0]       mem_addr,
   input logic                    issue
);
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && absorb_ready) |=> blk_valid);

   a_r8_block_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && absorb_ready) |=> ($stable(blk_data) && $stable(blk_last)));

   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && !absorb_ready) |=> !blk_valid);

   a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      blk_last |-> blk_valid);

   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && issue && $past(issue)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   a_r9_no_fetch_while_presenting: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid |-> !issue);
endmodule

bind sponge_block_asm sba_checker #(
   .RATE_BYTES(RATE_BYTES),
   .ADDR_W    (ADDR_W)
) u_sba_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .blk_valid   (blk_valid),
   .blk_last    (blk_last),
   .blk_data    (blk_data),
   .absorb_ready(absorb_ready),
   .mem_addr    (mem_addr),
   .issue       (issue)
);

// File: tb/sponge_block_asm_bench.sv
module sponge_block_asm_bench;
   localparam int RATE = 136;
   localparam int PFX  = 32;
   localparam int BB   = RATE * 8;
   localparam int PERM_CYC = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          mode = 1'b0;
   logic [11:0]   msg_len = '0;
   logic [PFX*8-1:0] prefix = '0;
   logic [11:0]   mem_addr;
   logic [7:0]    mem_rdata = 8'h00;
   logic          absorb_ready = 1'b1;
   logic [BB-1:0] blk_data;
   logic          blk_valid;
   logic          blk_last;

   always #10 clk = ~clk;

   sponge_block_asm u_sponge_block_asm (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .msg_len(msg_len), .prefix(prefix), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .absorb_ready(absorb_ready),
      .blk_data(blk_data), .blk_valid(blk_valid), .blk_last(blk_last)
   );

   logic [7:0] mem [0:4095];
   always @(posedge clk) mem_rdata <= mem[mem_addr];

   int checks = 0;
   int fails  = 0;
   int got_blocks = 0;
   int hold_cyc = 0;
   int cur_len = 0;
   int cur_nblk = 0;
   int blk_no = 0;
   bit finished = 0;
   logic [PFX*8-1:0] pfx_v;
   logic [BB:0] exp_q[$];

   function automatic logic [7:0] exp_byte(int g, int len, bit md, int nblk);
      logic [7:0] v;
      if (g < PFX)       v = pfx_v[8*g +: 8];
      else if (g < len)  v = mem[g - PFX];
      else if (g == len) v = md ? 8'h1F : 8'h06;
      else               v = 8'h00;
      if (g == nblk * RATE - 1) v = v | 8'h80;
      return v;
   endfunction

   function automatic string req_of(int g, int len, int nblk);
      if (g == nblk * RATE - 1) return "R6";
      if (g < PFX)  return "R2";
      if (g < len)  return "R3";
      if (g == len) return "R4";
      return "R5";
   endfunction

   task automatic report;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   // scoreboard monitor plus core stub
   initial begin
      forever begin
         @(negedge clk);
         if (blk_valid && absorb_ready) begin
            logic [BB:0] cap;
            logic [BB:0] ex;
            bit bad;
            cap = {blk_last, blk_data};
            bad = 0;
            for (int h = 0; h < hold_cyc; h++) begin
               @(negedge clk);
               if (!blk_valid || {blk_last, blk_data} != cap) bad = 1;
            end
            checks++;
            if (bad) begin
               fails++;
               $display("FAIL R8 block %0d not held: valid=%0b expected held 1", blk_no, blk_valid);
            end
            absorb_ready = 1'b0;
            if (exp_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL R7 unexpected block: got block %0d expected none", blk_no);
            end else begin
               ex = exp_q.pop_front();
               checks++;
               if (cap[BB-1:0] != ex[BB-1:0]) begin
                  fails++;
                  for (int p = 0; p < RATE; p++) begin
                     if (cap[8*p +: 8] != ex[8*p +: 8]) begin
                        $display("FAIL %s block %0d byte %0d: actual %02h expected %02h",
                                 req_of(blk_no*RATE + p, cur_len, cur_nblk), blk_no, p,
                                 cap[8*p +: 8], ex[8*p +: 8]);
                        break;
                     end
                  end
               end
               checks++;
               if (cap[BB] != ex[BB]) begin
                  fails++;
                  $display("FAIL R7 last flag block %0d: actual %0b expected %0b", blk_no, cap[BB], ex[BB]);
               end
            end
            bad = 0;
            for (int p = 0; p < PERM_CYC; p++) begin
               @(negedge clk);
               if (blk_valid) bad = 1;
            end
            checks++;
            if (bad) begin
               fails++;
               $display("FAIL R9 valid during permutation: actual 1 expected 0");
            end
            absorb_ready = 1'b1;
            blk_no++;
            got_blocks++;
         end
      end
   end

   task automatic run_msg(input int len, input bit md, input int seed, input int hold);
      int nblk;
      logic [BB:0] vec;
      nblk = len / RATE + 1;
      for (int a = 0; a < 4096; a++) mem[a] = 8'(a * 13 + seed + (a >> 8) * 5);
      for (int i = 0; i < PFX; i++) pfx_v[8*i +: 8] = 8'(i * 29 + seed * 3 + 1);
      for (int b = 0; b < nblk; b++) begin
         for (int p = 0; p < RATE; p++) vec[8*p +: 8] = exp_byte(b*RATE + p, len, md, nblk);
         vec[BB] = (b == nblk - 1);
         exp_q.push_back(vec);
      end
      cur_len = len; cur_nblk = nblk; blk_no = 0; got_blocks = 0; hold_cyc = hold;
      @(negedge clk);
      msg_len = 12'(len); mode = md; prefix = pfx_v; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (got_blocks < nblk) @(negedge clk);
      repeat (RATE + 40) @(negedge clk);
      // R7: exact block count, and no block without a new start (R9)
      checks++;
      if (got_blocks != nblk || exp_q.size() != 0) begin
         fails++;
         $display("FAIL R7 len %0d blocks: actual %0d expected %0d", len, got_blocks, nblk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (blk_valid !== 1'b0 || blk_last !== 1'b0 || blk_data !== '0) begin
         fails++;
         $display("FAIL R1 in reset: valid=%0b last=%0b expected 0/0/zero block", blk_valid, blk_last);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (blk_valid !== 1'b0 || blk_last !== 1'b0 || blk_data !== '0) begin
         fails++;
         $display("FAIL R1 after reset: valid=%0b last=%0b expected 0/0/zero block", blk_valid, blk_last);
      end
      run_msg(800, 1'b1, 3, 0);   // R7: 6 blocks
      run_msg(1120, 1'b1, 5, 2);  // R7: 9 blocks
      run_msg(1600, 1'b1, 7, 1);  // R7: 12 blocks
      run_msg(272, 1'b0, 9, 3);   // exact boundary: full padding block (R5, R6)
      run_msg(408, 1'b1, 11, 0);  // exact boundary, SHAKE suffix
      run_msg(135, 1'b0, 13, 1);  // R6 combined 0x86
      run_msg(135, 1'b1, 15, 2);  // R6 combined 0x9F
      run_msg(271, 1'b0, 17, 0);  // suffix on final byte of second block
      run_msg(32, 1'b0, 19, 1);   // prefix only (R2, R4)
      run_msg(100, 1'b1, 21, 0);
      finished = 1;
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         report();
         $finish;
      end
   end
endmodule